// File: doc/BRIEF.md
# Duplicate-Step Synchronous JK Counter

This block is a synchronous counter whose visible 2-bit value holds each number for two clocks. It walks 0, 0, 1, 1, 2, 2, 3, 3, then starts again at 0 and repeats for as long as it is clocked. The counter is built from JK flip-flop cells. Each cell's J and K inputs come from steering logic worked out from the JK excitation table.

Two cells cannot tell the first clock of a value from the second, so a third cell acts as a hidden phase bit. The phase bit toggles on every clock. The count cells advance only on the clock after the phase bit has been 1.

The count value is an output, and the full state word is also brought out for checking. The state word is {phase, count}, with the phase bit as the most significant bit. All cells share one clock. A synchronous active-low reset clears every cell and takes priority over the J and K inputs.

Top module: `dup_step_counter`

## Requirements
- R1: In the cycle after a clock edge that samples rst_n low, state_o reads 3'b000 and count_o reads 0.
- R2: While rst_n is high, state_o[2] (the phase bit) inverts on every rising clock edge.
- R3: On an edge where the phase bit was 0 before the edge, count_o keeps its value.
- R4: On an edge where the phase bit was 1 before the edge, count_o becomes its old value plus one, modulo 4.
- R5: After reset is released, count_o reads 0, 0, 1, 1, 2, 2, 3, 3 on successive clocks, and that sequence repeats.
- R6: After reset is released, state_o steps through 000, 100, 001, 101, 010, 110, 011, 111 (binary, phase bit first) and then returns to 000.
- R7: count_o always equals state_o[1:0]. The phase bit never shows in count_o.
- R8: Asserting rst_n low in the middle of the sequence returns state_o to 000 at the next edge, whatever the J and K inputs are.
- R9: While rst_n stays low over several edges, state_o stays at 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every JK cell |
| rst_n | input | 1 | Synchronous reset, active low |
| count_o | output | CNT_W (2) | Visible count value |
| state_o | output | CNT_W+1 (3) | Full state word {phase, count} |

## Verification
The bench builds the block with its default CNT_W of 2. That gives three JK cells and an eight-code state cycle, so 24 clocks cover three full laps. Both wrap points, 3 to 0 in the count and 111 to 000 in the state, are therefore reached several times. A reset applied partway through a lap checks that reset overrides cells whose steering is set to toggle.

// File: rtl/dup_step_counter_pkg.sv
// Package: shared JK cell encodings and the next-state helper.
// Assumes J is the upper bit of the two-bit control word.
package dup_step_counter_pkg;

    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_CLEAR  = 2'b01,
        JK_SET    = 2'b10,
        JK_TOGGLE = 2'b11
    } jk_ctrl_e;

    // Characteristic equation of a JK cell: Q+ = J & ~Q | ~K & Q
    function automatic logic jk_next(input logic j, input logic k, input logic q);
        jk_ctrl_e c;
        c = jk_ctrl_e'({j, k});
        case (c)
            JK_HOLD:   jk_next = q;
            JK_CLEAR:  jk_next = 1'b0;
            JK_SET:    jk_next = 1'b1;
            default:   jk_next = ~q;
        endcase
    endfunction

endpackage

// File: rtl/dup_step_jk_cell.sv
// Module: one JK flip-flop cell.
// Assumes a single rising-edge clock and a synchronous active-low reset
// that has priority over J and K.
module dup_step_jk_cell
    import dup_step_counter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic j,
    input  logic k,
    output logic q
);

    logic q_r;

    // Cell register: clear on reset, otherwise apply the JK rule
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= jk_next(j, k, q_r);
    end

    assign q = q_r;

endmodule

// File: rtl/dup_step_steer.sv
// Module: J/K steering for the phase cell and the count cells.
// Excitation-table result: phase cell J=K=1. Count bit i has J=K equal to
// the phase bit ANDed with every lower count bit.
// Assumes the state word is {phase, count}.
module dup_step_steer #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W:0] state,
    output logic [CNT_W:0] j_vec,
    output logic [CNT_W:0] k_vec
);

    localparam int PH = CNT_W;

    logic [CNT_W:0] carry;

    // Carry chain seeded by the phase bit
    assign carry[0] = state[PH];

    genvar g;
    generate
        for (g = 0; g < CNT_W; g++) begin : g_cnt
            assign carry[g+1] = carry[g] & state[g];
            assign j_vec[g]   = carry[g];
            assign k_vec[g]   = carry[g];
        end
    endgenerate

    // Phase cell toggles every clock
    assign j_vec[PH] = 1'b1;
    assign k_vec[PH] = 1'b1;

endmodule

// File: rtl/dup_step_counter.sv
// Module: top of the duplicate-step counter. It holds each count value
// for two clocks by means of a hidden phase cell.
// Assumes one shared clock and a synchronous active-low reset.
module dup_step_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W:0]   state_o
);

    localparam int NCELL = CNT_W + 1;

    logic [NCELL-1:0] q_vec;
    logic [NCELL-1:0] j_vec;
    logic [NCELL-1:0] k_vec;

    dup_step_steer #(.CNT_W(CNT_W)) u_steer (
        .state (q_vec),
        .j_vec (j_vec),
        .k_vec (k_vec)
    );

    genvar c;
    generate
        for (c = 0; c < NCELL; c++) begin : g_cell
            dup_step_jk_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .j     (j_vec[c]),
                .k     (k_vec[c]),
                .q     (q_vec[c])
            );
        end
    endgenerate

    // Output selection: the count cells only, without the phase cell
    assign count_o = q_vec[CNT_W-1:0];
    assign state_o = q_vec;

endmodule

// File: rtl/dup_step_counter_chk.sv
// Module: assertion checker bound to the top module.
// Assumes the state word is {phase, count}.
module dup_step_counter_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W:0]   state_o
);

    logic seen     = 1'b0;
    logic prev_rst = 1'b0;

    // Track the first edge and whether reset was sampled at the previous edge
    always_ff @(posedge clk) begin
        seen     <= 1'b1;
        prev_rst <= !rst_n;
        if (prev_rst) begin
            a_r1_reset_clears: assert (state_o == '0);
        end
    end

    a_r2_phase_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> state_o[CNT_W] != $past(state_o[CNT_W]));

    a_r3_hold_on_even: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !state_o[CNT_W]) |=> $stable(count_o));

    a_r4_step_on_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && state_o[CNT_W]) |=> count_o == CNT_W'($past(count_o) + 1'b1));

endmodule

bind dup_step_counter dup_step_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_o (count_o),
    .state_o (state_o)
);

// File: tb/dup_step_counter_tb_top.sv
module dup_step_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] count_o;
    logic [2:0] state_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic       m_ph  = 1'b0;
    logic [1:0] m_cnt = 2'd0;

    always #10 clk = ~clk;

    dup_step_counter dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count_o),
        .state_o (state_o)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One clock: model update, then sampling at the falling edge
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_ph = 1'b0; m_cnt = 2'd0;
        end else begin
            if (m_ph) m_cnt = m_cnt + 2'd1;
            m_ph = ~m_ph;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R9 state held in reset", state_o, 3'b000);
        end
        chk("R1 count after reset", {1'b0, count_o}, 3'b000);
    endtask

    task automatic t_sequence();
        logic [1:0] seq [8] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
        logic [2:0] st  [8] = '{3'b000, 3'b100, 3'b001, 3'b101,
                                3'b010, 3'b110, 3'b011, 3'b111};
        rst_n = 1'b1;
        chk("R5 first value", {1'b0, count_o}, 3'b000);
        for (int i = 1; i <= 24; i++) begin
            tick();
            chk("R5 count sequence", {1'b0, count_o}, {1'b0, seq[i % 8]});
            chk("R6 state order", state_o, st[i % 8]);
            chk("R7 count matches low state", {1'b0, count_o}, {1'b0, state_o[1:0]});
            chk("R2 R3 R4 model", state_o, {m_ph, m_cnt});
        end
    endtask

    task automatic t_midreset();
        rst_n = 1'b1;
        for (int i = 0; i < 7; i++) tick();
        chk("R8 pre-reset state", state_o, 3'b111);
        rst_n = 1'b0;
        tick();
        chk("R8 mid-sequence reset", state_o, 3'b000);
        rst_n = 1'b1;
        tick();
        chk("R2 phase after release", state_o, 3'b100);
        tick();
        chk("R4 step after release", state_o, 3'b001);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequence();
        t_reset();
        t_midreset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule